// File: doc/BRIEF.md
# Beacon Activation and Startup Controller

This controller decides when an emergency locator beacon is on and brings its transmit side up in order. Automatic activation comes from a debounced impact switch. It is honoured only while the unit sits in its mounting tray. A crew member can also activate the beacon by holding the cockpit panel switch or the unit switch at ON. An accidental activation is cleared with a quick flick: move either switch to ON and return it at once. A separate test-reset input also clears the beacon during on-board checks.

While the beacon is active, the controller drives the crash-mode supply enable and the buzzer output together, and it flashes a panel lamp. Once power is up it waits for the frequency synthesizer to report lock. It then sends one single-cycle read request to the position memory. If lock does not arrive within a timeout, an error flag rises and the controller keeps waiting. All timing is counted in ticks from a prescaler of the system clock. The clock divider, flash half-period, gesture window and lock timeout are all parameters.

Top module: `beacon_activation_ctrl`

## Requirements
- R1: After reset, supply_en_o, buzzer_o, lamp_o, pos_rd_o and lock_err_o are all 0 and the beacon is inactive.
- R2: impact_i high while mounted_i is high activates the beacon at the next clock edge. From that edge supply_en_o, buzzer_o and lamp_o are all 1.
- R3: impact_i is ignored while mounted_i is low, so all outputs stay 0.
- R4: Holding panel_on_i or unit_on_i at 1 (ON) for GESTURE_TICKS ticks activates the beacon. The edge at which this happens is the GESTURE_TICKS-th tick of that switch's own prescaler, which restarts each time the switch goes to ON.
- R5: A switch that returns from 1 to 0 before its GESTURE_TICKS-th tick clears an active beacon at the edge where the return is seen. In the inactive state this gesture has no effect.
- R6: An activation request (impact while mounted, or a long hold) takes priority over any clear in the same cycle, and the beacon stays active. A switch position never blocks impact activation.
- R7: A high test_reset_i clears the beacon unless an activation request is present in the same cycle.
- R8: On activation the lamp is lit at once. It then toggles every FLASH_TICKS ticks of a prescaler that restarts on activation. The lamp is 0 whenever the beacon is inactive.
- R9: pos_rd_o is a one-cycle pulse. It rises at the edge after pll_lock_i is first seen high while the beacon waits for lock. It is issued once per activation, and never without lock.
- R10: If lock has not come after LOCK_TICKS ticks of the activation prescaler, lock_err_o rises and the beacon keeps waiting. The flag stays set until the beacon is cleared.
- R11: Returning a switch to its rest position after a long hold leaves the beacon active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| impact_i | input | 1 | Debounced impact-switch closure |
| mounted_i | input | 1 | Unit seated in its tray |
| panel_on_i | input | 1 | Cockpit switch: 1 = ON, 0 = ARM |
| unit_on_i | input | 1 | Unit switch: 1 = ON, 0 = OFF |
| test_reset_i | input | 1 | On-board test reset, clears the beacon |
| pll_lock_i | input | 1 | Synthesizer lock indication |
| supply_en_o | output | 1 | Crash-mode supply enable |
| buzzer_o | output | 1 | Buzzer / light driver |
| lamp_o | output | 1 | Flashing panel indicator |
| pos_rd_o | output | 1 | Single-cycle read request for the stored position |
| lock_err_o | output | 1 | Lock timeout flag |

## Verification
A clear and an activation can land on the same edge. The bench ends a quick panel flick on the very cycle that the impact switch closes while mounted. It does the same with the test-reset input and an impact. The beacon must remain powered, and because the read was already issued, no second read pulse may appear. Expected read pulses are queued with the edge number at which lock is driven. Every observed pulse is matched against that queue, so a pulse that a clear should have suppressed is caught as an unexpected item.

// File: rtl/beacon_pkg.sv
package beacon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_LOCK = 2'd1,
    ST_LOCKED    = 2'd2
  } bcn_state_e;

  localparam int unsigned NUM_SWITCHES = 2;
endpackage

// File: rtl/bcn_tick_gen.sv
module bcn_tick_gen #(
  parameter int unsigned DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = ~clr & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick_o)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bcn_gesture.sv
module bcn_gesture #(
  parameter int unsigned TICK_DIV     = 125000,
  parameter int unsigned WINDOW_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_i,
  output logic long_o,
  output logic short_o
);
  localparam int unsigned HW = $clog2(WINDOW_TICKS + 1);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(WINDOW_TICKS);
  localparam logic [HW-1:0] HOLD_LAST = HW'(WINDOW_TICKS - 1);

  logic          tick;
  logic          sw_q;
  logic [HW-1:0] held;
  logic          sw_off;

  assign sw_off = ~sw_i;

  bcn_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sw_off),
    .tick_o (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= 1'b0;
      held <= '0;
    end else begin
      sw_q <= sw_i;
      if (!sw_i)                        held <= '0;
      else if (tick && held != HOLD_MAX) held <= held + 1'b1;
    end
  end

  assign long_o  = sw_i & tick & (held == HOLD_LAST);
  assign short_o = sw_q & ~sw_i & (held < HOLD_MAX);
endmodule

// File: rtl/bcn_flasher.sv
module bcn_flasher #(
  parameter int unsigned HALF_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic lamp_o
);
  localparam int unsigned FW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [FW-1:0] F_LAST = FW'(HALF_TICKS - 1);

  logic [FW-1:0] fcnt;
  logic          phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt  <= '0;
      phase <= 1'b1;
    end else if (!run) begin
      fcnt  <= '0;
      phase <= 1'b1;
    end else if (tick) begin
      if (fcnt == F_LAST) begin
        fcnt  <= '0;
        phase <= ~phase;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign lamp_o = run & phase;
endmodule

// File: rtl/beacon_activation_ctrl.sv
module beacon_activation_ctrl
  import beacon_pkg::*;
#(
  parameter int unsigned TICK_DIV      = 125000,
  parameter int unsigned FLASH_TICKS   = 500,
  parameter int unsigned GESTURE_TICKS = 2000,
  parameter int unsigned LOCK_TICKS    = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic impact_i,
  input  logic mounted_i,
  input  logic panel_on_i,
  input  logic unit_on_i,
  input  logic test_reset_i,
  input  logic pll_lock_i,
  output logic supply_en_o,
  output logic buzzer_o,
  output logic lamp_o,
  output logic pos_rd_o,
  output logic lock_err_o
);
  localparam int unsigned LW = $clog2(LOCK_TICKS + 1);
  localparam logic [LW-1:0] WAIT_LAST = LW'(LOCK_TICKS - 1);

  bcn_state_e              state_q, state_d;
  logic [NUM_SWITCHES-1:0] sw_vec, long_vec, short_vec;
  logic                    act_req, clr_req, clear_now;
  logic                    active, idle_tick_clr, tick;
  logic                    rd_d, rd_q;
  logic [LW-1:0]           wait_cnt;
  logic                    err_q;

  assign sw_vec = {unit_on_i, panel_on_i};

  for (genvar g = 0; g < NUM_SWITCHES; g++) begin : g_sw
    bcn_gesture #(
      .TICK_DIV     (TICK_DIV),
      .WINDOW_TICKS (GESTURE_TICKS)
    ) u_gesture (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_i    (sw_vec[g]),
      .long_o  (long_vec[g]),
      .short_o (short_vec[g])
    );
  end

  assign active        = (state_q != ST_IDLE);
  assign idle_tick_clr = ~active;

  bcn_tick_gen #(.DIV(TICK_DIV)) u_act_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (idle_tick_clr),
    .tick_o (tick)
  );

  bcn_flasher #(.HALF_TICKS(FLASH_TICKS)) u_flash (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active),
    .tick   (tick),
    .lamp_o (lamp_o)
  );

  // Activation requests always dominate clears in the same cycle.
  assign act_req   = (impact_i & mounted_i) | (|long_vec);
  assign clr_req   = (|short_vec) | test_reset_i;
  assign clear_now = clr_req & ~act_req;

  always_comb begin
    state_d = state_q;
    rd_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (act_req) state_d = ST_WAIT_LOCK;
      end
      ST_WAIT_LOCK: begin
        if (clear_now) begin
          state_d = ST_IDLE;
        end else if (pll_lock_i) begin
          state_d = ST_LOCKED;
          rd_d    = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (clear_now) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
    end
  end

  // Lock timeout: counts activation ticks while waiting; sticky until clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      err_q    <= 1'b0;
    end else if (state_d == ST_IDLE) begin
      wait_cnt <= '0;
      err_q    <= 1'b0;
    end else if (state_q == ST_WAIT_LOCK && tick && !err_q) begin
      if (wait_cnt == WAIT_LAST) err_q    <= 1'b1;
      else                       wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assign supply_en_o = active;
  assign buzzer_o    = active;
  assign pos_rd_o    = rd_q;
  assign lock_err_o  = err_q;
endmodule

// File: rtl/bcn_ctrl_checker.sv
module bcn_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic impact_i,
  input logic mounted_i,
  input logic pll_lock_i,
  input logic supply_en_o,
  input logic buzzer_o,
  input logic lamp_o,
  input logic pos_rd_o,
  input logic lock_err_o
);
  a_r2_impact_powers_up: assert property (@(posedge clk) disable iff (!rst_n)
    (impact_i && mounted_i) |=> (supply_en_o && buzzer_o && lamp_o));

  a_r6_impact_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_en_o && impact_i && mounted_i) |=> supply_en_o);

  a_r8_lamp_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_o |-> supply_en_o);

  a_r9_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pos_rd_o |=> !pos_rd_o);

  a_r9_read_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_rd_o) |-> ($past(pll_lock_i) && supply_en_o));

  a_r10_err_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err_o |-> supply_en_o);
endmodule

bind beacon_activation_ctrl bcn_ctrl_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .impact_i    (impact_i),
  .mounted_i   (mounted_i),
  .pll_lock_i  (pll_lock_i),
  .supply_en_o (supply_en_o),
  .buzzer_o    (buzzer_o),
  .lamp_o      (lamp_o),
  .pos_rd_o    (pos_rd_o),
  .lock_err_o  (lock_err_o)
);

// File: tb/beacon_activation_ctrl_tb.sv
module beacon_activation_ctrl_tb;
  localparam int unsigned D = 4;
  localparam int unsigned F = 3;
  localparam int unsigned G = 5;
  localparam int unsigned L = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic impact = 0, mounted = 0, panel = 0, unit_sw = 0, treset = 0, lock = 0;
  logic supply, buzzer, lamp, rd, err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  int k, j;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  beacon_activation_ctrl #(
    .TICK_DIV(D), .FLASH_TICKS(F), .GESTURE_TICKS(G), .LOCK_TICKS(L)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .impact_i(impact), .mounted_i(mounted),
    .panel_on_i(panel), .unit_on_i(unit_sw), .test_reset_i(treset),
    .pll_lock_i(lock), .supply_en_o(supply), .buzzer_o(buzzer),
    .lamp_o(lamp), .pos_rd_o(rd), .lock_err_o(err)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic chk_active(input string req, input logic exp);
    check(supply === exp, req, supply, exp);
    check(buzzer === exp, req, buzzer, exp);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: raise lock, queue expected read edge if a read is due.
  task automatic drive_lock(input bit expect_read);
    lock = 1'b1;
    if (expect_read) exp_q.push_back(cyc + 1);
  endtask

  // Monitor: every read pulse must match the head of the queue.
  always @(negedge clk) begin
    if (rst_n && rd === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected read", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(e == cyc, "R9 read edge", cyc, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    check({supply, buzzer, lamp, rd, err} === 5'b0, "R1", {supply, buzzer, lamp, rd, err}, 0);
    rst_n = 1'b1;
    step(2);
    check({supply, buzzer, lamp, rd, err} === 5'b0, "R1 after release", {supply, buzzer, lamp, rd, err}, 0);

    // R3 impact while unmounted
    impact = 1; step(10); impact = 0;
    chk_active("R3", 1'b0);
    check(lamp === 1'b0, "R3 lamp", lamp, 0);

    // R2 impact while mounted (switches at ARM/OFF: R6 never blocked)
    mounted = 1; impact = 1; step(1); impact = 0;
    k = cyc;
    chk_active("R2", 1'b1);
    check(lamp === 1'b1, "R2 lamp", lamp, 1);

    // R8 flash timing
    wait_to(k + D*F - 1); check(lamp === 1'b1, "R8 before toggle", lamp, 1);
    wait_to(k + D*F);     check(lamp === 1'b0, "R8 first toggle", lamp, 0);
    wait_to(k + 2*D*F);   check(lamp === 1'b1, "R8 second toggle", lamp, 1);

    // R10 lock timeout
    wait_to(k + D*L - 1); check(err === 1'b0, "R10 before timeout", err, 0);
    wait_to(k + D*L);     check(err === 1'b1, "R10 timeout", err, 1);
    step(5); chk_active("R10 keeps waiting", 1'b1);

    // R9 read after lock, once
    drive_lock(1'b1); step(12);
    check(exp_q.size() == 0, "R9 read seen", exp_q.size(), 0);
    check(err === 1'b1, "R10 sticky", err, 1);

    // R6 clear gesture and impact in the same cycle
    panel = 1; step(3); panel = 0; impact = 1; step(1); impact = 0;
    step(3); chk_active("R6 activation wins", 1'b1);

    // R5 short panel flick clears
    panel = 1; step(3); panel = 0; step(1);
    chk_active("R5 panel clear", 1'b0);
    check(lamp === 1'b0, "R8 lamp off when idle", lamp, 0);
    check(err === 1'b0, "R10 cleared", err, 0);

    // R5 flick while idle has no effect
    unit_sw = 1; step(3); unit_sw = 0; step(30);
    chk_active("R5 idle flick ignored", 1'b0);
    lock = 0; step(2);

    // R4 long unit hold
    unit_sw = 1; j = cyc + 1;
    wait_to(j + G*D - 2); chk_active("R4 before window", 1'b0);
    wait_to(j + G*D - 1); chk_active("R4 unit long hold", 1'b1);
    wait_to(j + 30); unit_sw = 0; step(5);
    chk_active("R11 release after hold", 1'b1);
    drive_lock(1'b1); step(6);

    // R7 test reset clears; lock held high gives no read while idle
    treset = 1; step(1); treset = 0;
    chk_active("R7 test reset", 1'b0);
    step(5); lock = 0; step(2);

    // R4 long panel hold, R11 release
    panel = 1; step(G*D + 5); panel = 0; step(3);
    chk_active("R4 panel long hold", 1'b1);
    chk_active("R11 panel release", 1'b1);

    // R7 test reset loses to impact in the same cycle
    treset = 1; impact = 1; step(1); treset = 0; impact = 0;
    step(2); chk_active("R7 activation wins", 1'b1);
    treset = 1; step(1); treset = 0;
    chk_active("R7 test reset alone", 1'b0);

    step(10);
    check(exp_q.size() == 0, "R9 no pending reads", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule